// File: doc/BRIEF.md
# Modulo PWM Timer with Direct-Write Compare Channel

This block counts prescaled bus-clock ticks with a 16-bit up-counter that returns to zero after it reaches a programmable modulo value. A single output-compare channel then shapes a pulse-width-modulated pin. The pin goes high at the start of every period and drops when the count reaches the channel's width value. The period is therefore the modulo plus one tick, and the high time is the width in ticks.

Both the modulo and the width are written straight into the live registers through a small register-write port. No shadow copy waits for the period boundary. A width written at a careless moment can make the counter skip the compare for one period, so the pin stays high across the boundary. Two sticky flags support safe updates, each with its own interrupt enable. The overflow flag marks the end of a period and is the moment to lengthen the pulse. The compare flag marks the end of a pulse and is the moment to shorten it.

Top module: `pwm_modtimer`

## Requirements
- R1: During and directly after synchronous reset, count_o is 0, pwm_out is low, both flags and both interrupt requests are low, the prescaler select is 0, both enables are 0, the width is 0 and the modulo is 0xFFFF.
- R2: The prescaler is a 6-bit count of bus clocks that starts at 0 after reset and advances every cycle. The counter takes a tick in each cycle in which the low `sel` bits of this count are all ones. Select values 0 to 6 therefore divide by 1, 2, 4, 8, 16, 32 and 64, and select 7 also divides by 64.
- R3: On each tick the counter adds one. On a tick where the count equals the modulo, it reloads to 0 instead. A period is therefore modulo+1 ticks long.
- R4: pwm_out goes high on the reload tick. It goes low on the tick that brings the count to the width value, and a low-going compare wins over a reload in the same tick. The pin is therefore high for `width` ticks of each period, stays low when width is 0, and stays high when width is greater than the modulo.
- R5: A write takes effect in the register file one clock after wr_en is sampled. Address 0 is control: bits 2:0 select the prescaler, bit 4 enables the overflow interrupt and bit 5 enables the compare interrupt. Address 1 is the modulo and address 2 is the width. A write to address 3 changes nothing.
- R6: A width write lands at once, with no buffering. If the count has already passed the new width, no compare happens in that period, and the pin stays high through the reload until the new width is reached in the next period.
- R7: ovf_flag is set by every reload tick and stays set until it is cleared.
- R8: cmp_flag is set by every compare tick and stays set until it is cleared.
- R9: A one-cycle pulse on clr_ovf or clr_cmp clears the matching flag. If an event sets that flag in the same cycle, the event wins and the flag stays set.
- R10: ovf_irq is high exactly when ovf_flag is set and the overflow enable is set. cmp_irq is high exactly when cmp_flag is set and the compare enable is set.
- R11: If the modulo is written below the current count, the counter runs on to 0xFFFF and wraps to 0 without a reload event. ovf_flag stays clear until the count next equals the modulo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 modulo, 2 width, 3 unused |
| wr_data | input | 16 | Write data |
| clr_ovf | input | 1 | Write-one-to-clear pulse for the overflow flag |
| clr_cmp | input | 1 | Write-one-to-clear pulse for the compare flag |
| count_o | output | 16 | Current counter value |
| pwm_out | output | 1 | PWM pin |
| ovf_flag | output | 1 | Sticky period-end flag |
| cmp_flag | output | 1 | Sticky pulse-end flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Every result is registered. The count, pin and flags that belong to the tick decided in cycle N become visible one clock after that edge. A register write or a clear pulse sampled at an edge first acts on the tick decision of the following cycle. The bench drives inputs on the falling edge and keeps a behavioural model that it advances on the rising edge. On every falling edge it compares all outputs with the model. The scenario checks measure periods and high times in whole cycles between observed pin edges. They place each write or clear on the falling edge just before the rising edge at which it must land, using the model to find the cycle in which an overflow is due.

// File: rtl/pwm_modtimer_pkg.sv
package pwm_modtimer_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_MOD   = 2'd1,
        REG_WIDTH = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    localparam int CTRL_SEL_LSB = 0;
    localparam int CTRL_OVF_IE  = 4;
    localparam int CTRL_CMP_IE  = 5;

    localparam int FLG_OVF   = 0;
    localparam int FLG_CMP   = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PSC_W = MAX_LOG;

    typedef struct packed {
        logic [PSC_W-1:0] acc;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [SEL_W-1:0] eff_sel;
    logic [PSC_W:0]   span;
    logic [PSC_W-1:0] mask;

    always_comb begin
        eff_sel = (sel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : sel;
        span    = (PSC_W+1)'(1) << eff_sel;
        mask    = PSC_W'(span - (PSC_W+1)'(1));
        tick    = ((st_q.acc & mask) == mask);
        st_d.acc = st_q.acc + PSC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             ovf_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ovf_evt = tick && (st_q.cnt == mod_val);
        if (ovf_evt)   st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        cnt_nxt = st_d.cnt;
        cnt     = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ovf_evt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] width,
    output logic             pin,
    output logic             cmp_evt
);
    typedef struct packed {
        logic pin;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cmp_evt = tick && (cnt_nxt == width);
        if (cmp_evt)      st_d.pin = 1'b0;
        else if (ovf_evt) st_d.pin = 1'b1;
        pin = st_q.pin;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flag,
    output logic [NF-1:0] irq
);
    typedef struct packed {
        logic [NF-1:0] flag;
    } flg_state_t;

    flg_state_t st_d, st_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_comb begin
            st_d.flag[i] = set[i] | (st_q.flag[i] & ~clr[i]);
            flag[i]      = st_q.flag[i];
            irq[i]       = st_q.flag[i] & en[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwm_modtimer.sv
module pwm_modtimer
    import pwm_modtimer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_ovf,
    input  logic             clr_cmp,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             ovf_irq,
    output logic             cmp_irq
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ovf_ie;
        logic             cmp_ie;
        logic [CNT_W-1:0] mod_val;
        logic [CNT_W-1:0] width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                REG_CTRL: begin
                    cfg_d.sel    = wr_data[CTRL_SEL_LSB +: SEL_W];
                    cfg_d.ovf_ie = wr_data[CTRL_OVF_IE];
                    cfg_d.cmp_ie = wr_data[CTRL_CMP_IE];
                end
                REG_MOD:   cfg_d.mod_val = wr_data;
                REG_WIDTH: cfg_d.width   = wr_data;
                REG_SPARE: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q         <= '0;
            cfg_q.mod_val <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic             tick;
    logic             ovf_evt;
    logic             cmp_evt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] width_q;
    logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_en, fl_q, fl_irq;

    assign mod_q   = cfg_q.mod_val;
    assign width_q = cfg_q.width;

    pwm_prescaler #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_psc (
        .clk(clk), .rst(rst), .sel(cfg_q.sel), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .mod_val(mod_q),
        .cnt(count_o), .cnt_nxt(cnt_nxt), .ovf_evt(ovf_evt)
    );

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst(rst), .tick(tick), .ovf_evt(ovf_evt),
        .cnt_nxt(cnt_nxt), .width(width_q), .pin(pwm_out), .cmp_evt(cmp_evt)
    );

    always_comb begin
        fl_set          = '0;
        fl_clr          = '0;
        fl_en           = '0;
        fl_set[FLG_OVF] = ovf_evt;
        fl_set[FLG_CMP] = cmp_evt;
        fl_clr[FLG_OVF] = clr_ovf;
        fl_clr[FLG_CMP] = clr_cmp;
        fl_en[FLG_OVF]  = cfg_q.ovf_ie;
        fl_en[FLG_CMP]  = cfg_q.cmp_ie;
    end

    pwm_flags #(.NF(NUM_FLAGS)) u_flg (
        .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr), .en(fl_en),
        .flag(fl_q), .irq(fl_irq)
    );

    assign ovf_flag = fl_q[FLG_OVF];
    assign cmp_flag = fl_q[FLG_CMP];
    assign ovf_irq  = fl_irq[FLG_OVF];
    assign cmp_irq  = fl_irq[FLG_CMP];
endmodule

// File: rtl/pwm_modtimer_chk.sv
module pwm_modtimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ovf_evt,
    input logic             cmp_evt,
    input logic [CNT_W-1:0] mod_q,
    input logic [CNT_W-1:0] width_q,
    input logic [CNT_W-1:0] count_o,
    input logic             pwm_out,
    input logic             ovf_flag,
    input logic             cmp_flag,
    input logic             clr_ovf,
    input logic             clr_cmp,
    input logic             ovf_irq,
    input logic             cmp_irq
);
    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count_o == mod_q) |=> (count_o == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count_o != mod_q) |=> (count_o == $past(count_o) + CNT_W'(1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_o));

    assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> (count_o == '0));

    assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_out) |-> (count_o == $past(width_q)));

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    assert_cmp_set_R8: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |=> cmp_flag);

    assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !ovf_evt) |=> !ovf_flag);

    assert_cmp_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_cmp && !cmp_evt) |=> !cmp_flag);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq |-> ovf_flag) and (cmp_irq |-> cmp_flag));
endmodule

bind pwm_modtimer pwm_modtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
    .mod_q(mod_q), .width_q(width_q), .count_o(count_o), .pwm_out(pwm_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .clr_ovf(clr_ovf),
    .clr_cmp(clr_cmp), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
);

// File: tb/sim_pwm_modtimer.sv
`timescale 1ns/1ps
module sim_pwm_modtimer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        clr_ovf = 1'b0;
    logic        clr_cmp = 1'b0;
    logic [15:0] count_o;
    logic        pwm_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

    always #5 clk = ~clk;

    pwm_modtimer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_ovf(clr_ovf), .clr_cmp(clr_cmp), .count_o(count_o), .pwm_out(pwm_out),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit run_cmp = 0;
    bit done = 0;

    // behavioural reference state
    int m_psc, m_cnt, m_mod, m_wid, m_sel;
    bit m_pwm, m_of, m_cf, m_oie, m_cie;

    function automatic bit m_tick_now();
        int d;
        d = (m_sel > 6) ? 64 : (1 << m_sel);
        return (m_psc % d) == d - 1;
    endfunction

    function automatic bit ovf_due();
        return m_tick_now() && (m_cnt == m_mod);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psc = 0; m_cnt = 0; m_mod = 65535; m_wid = 0; m_sel = 0;
            m_pwm = 0; m_of = 0; m_cf = 0; m_oie = 0; m_cie = 0;
        end else begin
            bit tk, ov, cm;
            int nc;
            tk = m_tick_now();
            ov = tk && (m_cnt == m_mod);
            nc = ov ? 0 : (tk ? (m_cnt + 1) % 65536 : m_cnt);
            cm = tk && (nc == m_wid);
            if (cm) m_pwm = 0;
            else if (ov) m_pwm = 1;
            m_of = ov || (m_of && !clr_ovf);
            m_cf = cm || (m_cf && !clr_cmp);
            m_cnt = nc;
            m_psc = (m_psc + 1) % 64;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_sel = int'(wr_data[2:0]); m_oie = wr_data[4]; m_cie = wr_data[5]; end
                    2'd1: m_mod = int'(wr_data);
                    2'd2: m_wid = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R3 count", int'(count_o), m_cnt);
            chk("R4 pwm", int'(pwm_out), int'(m_pwm));
            chk("R7 ovf_flag", int'(ovf_flag), int'(m_of));
            chk("R8 cmp_flag", int'(cmp_flag), int'(m_cf));
            chk("R10 ovf_irq", int'(ovf_irq), int'(m_of && m_oie));
            chk("R10 cmp_irq", int'(cmp_irq), int'(m_cf && m_cie));
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
            report();
            $finish;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        logic p;
        p = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out && !p) break;
            p = pwm_out;
        end
    endtask

    // from a rising edge to the next: cycles high and cycles total
    task automatic measure(output int hi, output int per);
        logic p;
        wait_rise();
        hi = 0; per = 0;
        do begin
            if (pwm_out) hi++;
            per++;
            p = pwm_out;
            @(negedge clk);
        end while (!(pwm_out && !p));
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    initial begin
        int hi, per;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 count in reset", int'(count_o), 0);
        chk("R1 pwm in reset", int'(pwm_out), 0);
        chk("R1 flags in reset", int'({ovf_flag, cmp_flag, ovf_irq, cmp_irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        run_cmp = 1;
        chk("R1 pwm after reset", int'(pwm_out), 0);

        // R3/R4/R5: 8-bit period, half duty
        reg_write(2'd0, 16'h0030);
        reg_write(2'd1, 16'd255);
        reg_write(2'd2, 16'd128);
        measure(hi, per);
        chk("R3 period mod255", per, 256);
        chk("R4 high width128", hi, 128);

        // R2: prescaler divide by 4, then select 7 (divide by 64)
        reg_write(2'd1, 16'd9);
        reg_write(2'd2, 16'd3);
        reg_write(2'd0, 16'h0032);
        measure(hi, per);
        chk("R2 period sel2", per, 40);
        chk("R2 high sel2", hi, 12);
        reg_write(2'd1, 16'd3);
        reg_write(2'd2, 16'd1);
        reg_write(2'd0, 16'h0037);
        measure(hi, per);
        chk("R2 period sel7", per, 256);
        chk("R2 high sel7", hi, 64);

        // R5: unused address changes nothing
        reg_write(2'd0, 16'h0030);
        reg_write(2'd1, 16'd15);
        reg_write(2'd2, 16'd5);
        measure(hi, per);
        reg_write(2'd3, 16'd1);
        measure(hi, per);
        chk("R5 period after addr3 write", per, 16);
        chk("R5 high after addr3 write", hi, 5);

        // R6: width moved below the count mid-period
        reg_write(2'd2, 16'd12);
        measure(hi, per);
        wait_rise();
        hi = 0;
        while (count_o != 16'd8) begin hi++; @(negedge clk); end
        wr_addr = 2'd2; wr_data = 16'd4; wr_en = 1'b1;
        hi++;
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm_out) begin hi++; @(negedge clk); end
        chk("R6 missed compare high run", hi, 20);
        measure(hi, per);
        chk("R6 next period high", hi, 4);

        // R4: width 0 stays low, width above modulo stays high
        reg_write(2'd2, 16'd0);
        repeat (32) @(negedge clk);
        count_high(32, hi);
        chk("R4 width0 high cycles", hi, 0);
        reg_write(2'd2, 16'd20);
        repeat (32) @(negedge clk);
        count_high(32, hi);
        chk("R4 width>mod high cycles", hi, 32);
        reg_write(2'd2, 16'd6);

        // R9: set wins over clear; plain clear
        while (!ovf_due()) @(negedge clk);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        chk("R9 set wins over clear", int'(ovf_flag), 1);
        while (ovf_due()) @(negedge clk);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        chk("R9 clear ovf", int'(ovf_flag), 0);
        wait (cmp_flag == 1'b1);
        @(negedge clk);
        clr_cmp = 1'b1;
        @(negedge clk);
        clr_cmp = 1'b0;
        chk("R9 clear cmp", int'(cmp_flag), 0);

        // R10: enables gate the requests
        reg_write(2'd0, 16'h0000);
        wait (ovf_flag == 1'b1);
        @(negedge clk);
        chk("R10 ovf_irq masked", int'(ovf_irq), 0);
        reg_write(2'd0, 16'h0010);
        chk("R10 ovf_irq enabled", int'(ovf_irq), 1);

        // R11: modulo written below the count; wrap without overflow
        reg_write(2'd1, 16'd1000);
        while (count_o != 16'd900) @(negedge clk);
        reg_write(2'd1, 16'd100);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        while (count_o != 16'd0) @(negedge clk);
        chk("R11 wrap sets no ovf_flag", int'(ovf_flag), 0);
        wait (ovf_flag == 1'b1);
        @(negedge clk);
        chk("R11 next overflow at modulo", int'(count_o), 0);

        repeat (4) @(negedge clk);
        run_cmp = 0;
        done = 1;
        report();
        $finish;
    end
endmodule